// File: doc/BRIEF.md
# Carry-Steered Add/Subtract Unit

This block is the arithmetic datapath of a small byte-wide processor. Two operand registers, W and Z, capture values from a shared input bus. Neither register ever drives that bus. A single adder forms W plus Z, or W plus the bitwise inverse of Z. The adder never changes. The operation is chosen by three things: how the carry-in is steered, whether Z is inverted, and whether Z has been cleared.

The carry-in comes from a two-input selector. It picks either the stored carry flag or a fixed level, and the result is then XORed with the subtract control. This gives plain add, plain subtract, add with carry and subtract with carry. Clearing Z through its own asynchronous input gives increment and decrement. With Z cleared and a zero carry-in, the result equals W, so W can be used as a scratch store.

The unit exports the following:
- the carry-out, corrected for subtraction
- the steered carry-in, offered as a candidate value for the carry flag
- the result sign bit
- both operand registers, for the neighbouring logic and shift units

The result reaches the output bus only while its active-low enable is low.

Top module: `arith_unit`

## Requirements
- R1: After reset the W and Z registers both read 0x00.
- R2: The steered carry-in `cin_out` equals (`use_flag` ? `flag_c` : `fixed_c`) XOR `sub`. The result equals W + (`sub` ? ~Z : Z) + `cin_out`, taken modulo 256.
- R3: `cout` equals the carry out of bit 7 of that addition, XOR `sub`. For a subtraction, 1 therefore means a borrow occurred.
- R4: W loads `bus_in` on a rising clock edge when `w_ld` is 1 and otherwise holds. Z does the same under `z_ld`.
- R5: `z_clr` at 1 forces Z to 0x00 at once, without waiting for a clock edge. It takes priority over a simultaneous `z_ld`.
- R6: `res_out` carries the result while `res_oe_n` is 0. It is high-impedance while `res_oe_n` is 1.
- R7: `sign` equals bit 7 of the result, whatever the state of `res_oe_n`.
- R8: With-carry forms use `use_flag`=1. ADC gives W+Z+`flag_c`. SBC gives W-Z-`flag_c`, so a flag of 1 borrows one more.
- R9: INC and DEC use Z=0, `use_flag`=0, `fixed_c`=1. INC (`sub`=0) gives W+1. DEC (`sub`=1) gives W-1.
- R10: Pass-through uses Z=0, `sub`=0, `use_flag`=0, `fixed_c`=0. The result then equals W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_in | input | 8 | Shared data bus, read by W and Z |
| w_ld | input | 1 | Load enable for W |
| z_ld | input | 1 | Load enable for Z |
| z_clr | input | 1 | Asynchronous clear of Z, active high |
| sub | input | 1 | Invert Z and the carries, for subtraction |
| use_flag | input | 1 | Carry-in source: 1 = stored flag, 0 = fixed level |
| fixed_c | input | 1 | Fixed carry level, used when `use_flag` is 0 |
| flag_c | input | 1 | Stored carry flag |
| res_oe_n | input | 1 | Active-low enable of the result output |
| res_out | output | 8 | Result, high-impedance when disabled |
| cout | output | 1 | Carry-out corrected for subtraction |
| cin_out | output | 1 | Steered carry-in value |
| sign | output | 1 | Result bit 7 |
| w_q | output | 8 | W contents |
| z_q | output | 8 | Z contents |

## Verification
A wrong value held in W or Z is visible directly on `w_q` and `z_q`. It also corrupts `res_out` and `sign` in the first sampling after the faulty clock edge, because the adder is purely combinational. A mis-steered carry shows up in the same cycle as an off-by-one result and as a wrong `cin_out`. A missing correction on the carry-out inverts `cout` on every subtraction. A Z clear that waited for a clock edge would leave Z non-zero between edges, and sampling mid-cycle catches that.

// File: rtl/arith_pkg.sv
package arith_pkg;
  parameter int unsigned DATA_W = 8;
  localparam int unsigned MSB = DATA_W - 1;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb pipe_d = {pipe_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rst_q_n = pipe_q[STAGES-1];
endmodule

// File: rtl/operand_reg.sv
module operand_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ld,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_next;

  always_comb q_next = ld ? d : q;

  always_ff @(posedge clk or negedge rst_n or posedge clr) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else          q <= q_next;
  end
endmodule

// File: rtl/carry_in_sel.sv
module carry_in_sel (
  input  logic use_flag,
  input  logic flag_c,
  input  logic fixed_c,
  input  logic sub,
  output logic cin
);
  logic raw_c;

  always_comb begin
    raw_c = use_flag ? flag_c : fixed_c;
    cin   = raw_c ^ sub;
  end
endmodule

// File: rtl/ripple_adder.sv
module ripple_adder #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b_raw,
  input  logic             sub,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout_adj
);
  logic [WIDTH:0]   chain;
  logic [WIDTH-1:0] b_eff;

  assign chain[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign b_eff[i]   = b_raw[i] ^ sub;
    assign sum[i]     = a[i] ^ b_eff[i] ^ chain[i];
    assign chain[i+1] = (a[i] & b_eff[i]) | (chain[i] & (a[i] ^ b_eff[i]));
  end

  assign cout_adj = chain[WIDTH] ^ sub;
endmodule

// File: rtl/arith_unit.sv
module arith_unit
  import arith_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_in,
  input  logic              w_ld,
  input  logic              z_ld,
  input  logic              z_clr,
  input  logic              sub,
  input  logic              use_flag,
  input  logic              fixed_c,
  input  logic              flag_c,
  input  logic              res_oe_n,
  output logic [DATA_W-1:0] res_out,
  output logic              cout,
  output logic              cin_out,
  output logic              sign,
  output logic [DATA_W-1:0] w_q,
  output logic [DATA_W-1:0] z_q
);
  logic  rst_q_n;
  word_t sum;
  logic  cin;

  rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  operand_reg #(.WIDTH(DATA_W)) u_w (
    .clk(clk), .rst_n(rst_q_n), .clr(1'b0), .ld(w_ld), .d(bus_in), .q(w_q)
  );

  operand_reg #(.WIDTH(DATA_W)) u_z (
    .clk(clk), .rst_n(rst_q_n), .clr(z_clr), .ld(z_ld), .d(bus_in), .q(z_q)
  );

  carry_in_sel u_csel (
    .use_flag(use_flag), .flag_c(flag_c), .fixed_c(fixed_c), .sub(sub), .cin(cin)
  );

  ripple_adder #(.WIDTH(DATA_W)) u_add (
    .a(w_q), .b_raw(z_q), .sub(sub), .cin(cin), .sum(sum), .cout_adj(cout)
  );

  assign cin_out = cin;
  assign sign    = sum[MSB];
  assign res_out = res_oe_n ? {DATA_W{1'bz}} : sum;
endmodule

// File: rtl/arith_unit_checker.sv
module arith_unit_checker
  import arith_pkg::*;
(
  input logic              clk,
  input logic              rst_q_n,
  input logic [DATA_W-1:0] bus_in,
  input logic              w_ld,
  input logic              z_ld,
  input logic              z_clr,
  input logic              sub,
  input logic              cin_out,
  input logic              cout,
  input logic [DATA_W-1:0] sum,
  input logic [DATA_W-1:0] w_q,
  input logic [DATA_W-1:0] z_q
);
  logic [DATA_W:0] ref_total;
  always_comb ref_total = {1'b0, w_q} + {1'b0, (sub ? ~z_q : z_q)} + {{DATA_W{1'b0}}, cin_out};

  a_r2_sum_matches: assert property (@(posedge clk) disable iff (!rst_q_n)
    sum == ref_total[DATA_W-1:0]);

  a_r3_carry_sense: assert property (@(posedge clk) disable iff (!rst_q_n)
    cout == (ref_total[DATA_W] ^ sub));

  a_r4_w_loads: assert property (@(posedge clk) disable iff (!rst_q_n)
    w_ld |=> w_q == $past(bus_in));

  a_r4_w_holds: assert property (@(posedge clk) disable iff (!rst_q_n)
    !w_ld |=> $stable(w_q));

  a_r5_z_cleared: assert property (@(posedge clk) disable iff (!rst_q_n)
    z_clr |-> z_q == '0);

  a_r5_z_clear_wins: assert property (@(posedge clk) disable iff (!rst_q_n)
    (z_clr && z_ld) |=> z_q == '0 || !$past(z_clr));
endmodule

bind arith_unit arith_unit_checker u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .bus_in(bus_in), .w_ld(w_ld), .z_ld(z_ld),
  .z_clr(z_clr), .sub(sub), .cin_out(cin_out), .cout(cout), .sum(sum),
  .w_q(w_q), .z_q(z_q)
);

// File: tb/arith_unit_bench.sv
`timescale 1ns/1ps
module arith_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_in;
  logic       w_ld, z_ld, z_clr, sub, use_flag, fixed_c, flag_c, res_oe_n;
  wire  [7:0] res_out;
  wire        cout, cin_out, sign;
  wire  [7:0] w_q, z_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  arith_unit u_arith_unit (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .w_ld(w_ld), .z_ld(z_ld),
    .z_clr(z_clr), .sub(sub), .use_flag(use_flag), .fixed_c(fixed_c),
    .flag_c(flag_c), .res_oe_n(res_oe_n), .res_out(res_out), .cout(cout),
    .cin_out(cin_out), .sign(sign), .w_q(w_q), .z_q(z_q)
  );

  // vector: {w, z, sub, use_flag, fixed_c, flag_c, expected result}
  localparam int NV = 11;
  localparam logic [27:0] VEC [NV] = '{
    {8'h3C, 8'h15, 4'b0000, 8'h51},  // ADD
    {8'hFF, 8'h01, 4'b0000, 8'h00},  // ADD wraps, carry
    {8'h50, 8'h20, 4'b1000, 8'h30},  // SUB no borrow
    {8'h20, 8'h50, 4'b1000, 8'hD0},  // SUB borrow
    {8'h10, 8'h20, 4'b0101, 8'h31},  // ADC flag 1
    {8'h10, 8'h20, 4'b0100, 8'h30},  // ADC flag 0
    {8'h50, 8'h20, 4'b1101, 8'h2F},  // SBC flag 1
    {8'h50, 8'h20, 4'b1100, 8'h30},  // SBC flag 0
    {8'h7F, 8'h00, 4'b0010, 8'h80},  // INC
    {8'h00, 8'h00, 4'b1010, 8'hFF},  // DEC
    {8'hA5, 8'h00, 4'b0000, 8'hA5}   // pass-through
  };

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] wv, input logic [7:0] zv);
    @(negedge clk); bus_in = wv; w_ld = 1'b1;
    @(negedge clk); w_ld = 1'b0; bus_in = zv; z_ld = 1'b1;
    @(negedge clk); z_ld = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; bus_in = '0; w_ld = 0; z_ld = 0; z_clr = 0;
    sub = 0; use_flag = 0; fixed_c = 0; flag_c = 0; res_oe_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 w after reset", {1'b0, w_q}, 9'h000);
    chk("R1 z after reset", {1'b0, z_q}, 9'h000);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] ew, ez, zop, exp_sum;
      logic       es, eu, ef, ec, ecin;
      logic [8:0] tot;
      {ew, ez, es, eu, ef, ec, exp_sum} = VEC[i];
      load(ew, ez);
      sub = es; use_flag = eu; fixed_c = ef; flag_c = ec;
      #1;
      ecin = (eu ? ec : ef) ^ es;
      zop  = es ? ~ez : ez;
      tot  = {1'b0, ew} + {1'b0, zop} + {8'h00, ecin};
      chk("R2 R8 R9 R10 result", {1'b0, res_out}, {1'b0, exp_sum});
      chk("R2 carry-in", {8'h00, cin_out}, {8'h00, ecin});
      chk("R3 carry-out", {8'h00, cout}, {8'h00, tot[8] ^ es});
      chk("R7 sign", {8'h00, sign}, {8'h00, exp_sum[7]});
    end

    // R3: DEC of 0 reports a borrow; INC of FF reports a carry
    load(8'h00, 8'h00); sub = 1; use_flag = 0; fixed_c = 1; #1;
    chk("R3 DEC borrow", {cout, res_out}, 9'h1FF);
    load(8'hFF, 8'h00); sub = 0; #1;
    chk("R9 INC wrap carry", {cout, res_out}, 9'h100);

    // R4: hold without load enables
    load(8'h12, 8'h34);
    @(negedge clk); bus_in = 8'hEE;
    @(negedge clk);
    chk("R4 w holds", {1'b0, w_q}, 9'h012);
    chk("R4 z holds", {1'b0, z_q}, 9'h034);

    // R5: asynchronous clear mid-cycle, then priority over a load
    #1 z_clr = 1'b1; #0.5;
    chk("R5 async clear", {1'b0, z_q}, 9'h000);
    @(negedge clk); bus_in = 8'h99; z_ld = 1'b1;
    @(negedge clk);
    chk("R5 clear beats load", {1'b0, z_q}, 9'h000);
    z_ld = 1'b0; z_clr = 1'b0;
    @(negedge clk);
    chk("R5 z stays clear", {1'b0, z_q}, 9'h000);

    // R10: pass-through with cleared Z
    sub = 0; use_flag = 0; fixed_c = 0; #1;
    chk("R10 pass W", {1'b0, res_out}, 9'h012);

    // R6/R7: output disabled goes high-impedance, sign still valid
    load(8'h90, 8'h00);
    res_oe_n = 1'b1; #1;
    checks++;
    if (res_out !== 8'bzzzzzzzz) begin
      fails++;
      $display("FAIL R6 disabled actual=%h expected=zz", res_out);
    end
    chk("R7 sign while disabled", {8'h00, sign}, 9'h001);
    res_oe_n = 1'b0; #1;
    chk("R6 enabled drives", {1'b0, res_out}, 9'h090);

    // R1: reset again clears loaded registers
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 w after re-reset", {1'b0, w_q}, 9'h000);
    rst_n = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule